// File: doc/BRIEF.md
# Multicast Copy Engine with Per-Slice Admission

This block sits behind the packet lookup stage. It takes one shim packet at a time: a buffer handle, a frame length, a result index, a unicast/multicast type bit, a copy mask, a slice number and a stats index. It then looks at a local result table. A unicast packet yields a single queue request carrying the original handle. A multicast packet yields one request per selected result entry. Each of those requests carries a fresh header buffer taken from a free-handle source. Every header buffer descriptor points at the shared payload buffer, and the payload descriptor records how many copies reference it.

Admission is controlled per slice. A packet that would emit at least one request is accepted only while the slice's current count is below its maximum. Refused packets are dropped and tallied. Buffer descriptors live in a small register file indexed by the low bits of a handle, and a readback port exposes them.

The controller is one state machine with five states. ST_IDLE waits for a packet and latches it (transition to ST_CHECK). ST_CHECK reads the table and the slice limit, then goes to ST_UC_SEND for an admitted unicast, to ST_MC_GRAB for an admitted multicast, or back to ST_IDLE on any drop. ST_UC_SEND presents the request and returns to ST_IDLE once it is accepted. ST_MC_GRAB waits for a free header handle, writes that handle's descriptor, and moves to ST_MC_SEND. ST_MC_SEND presents the copy with the lowest remaining index. When that copy is accepted, the state returns to ST_MC_GRAB if copies remain, and to ST_IDLE otherwise.

Top module: `mc_copy_engine`

## Requirements
- R1: After reset, pkt_ready is 1, q_valid is 0, drop_valid is 0 and every slice's current and over-limit counts read 0.
- R2: rt_wdata is laid out as [100] valid, [99:80] queue ID, [79:48] tunnel destination address, [47:32] destination port, [31:16] source port, [15:0] header-format index. Unicast entry i sits at table address i. An admitted unicast packet whose entry is valid produces exactly one request. That request carries the packet's handle, length and stats index, plus the entry's fields.
- R3: Queue ID bits [19:18] appear on q_qm, bits [17:15] on q_sched and bits [14:0] on q_queue.
- R4: A packet that would emit a request is admitted only when the slice's current count is below its maximum, and admission adds one to current. A refused packet pulses drop_valid for one cycle, adds one to the over-limit count and emits nothing. Loading a slice's maximum clears both of its counts.
- R5: Multicast entry k of block b sits at address UC_ENTRIES + b*FANOUT + k. Copies go out for every mask bit whose entry is valid, in ascending k. Each copy takes the next free header handle in order and carries entry k's fields.
- R6: For a multicast packet with nonzero length, the payload descriptor's reference count is set to the number of copies. Each header descriptor gets reference count 1, next = payload handle and chain flag 1.
- R7: For a multicast packet with zero length, pay_drop_valid pulses with the payload handle, the payload descriptor is left untouched, and the header descriptors get chain flag 0.
- R8: A mask bit whose entry is invalid is skipped and does not count toward the reference count. A packet with no valid target (an invalid unicast entry, or a mask with no valid entry) pulses drop_valid and leaves the slice counts unchanged.
- R9: While no free handle is offered, the engine waits without losing a copy. pkt_ready stays 0 until the last copy of a packet is accepted.
- R10: While q_valid is high and q_ready is low, q_valid stays high and the request fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Shim packet offered |
| pkt_ready | output | 1 | Engine can take a packet |
| pkt_handle | input | HANDLE_W | Payload buffer handle |
| pkt_len | input | LEN_W | Frame length |
| pkt_ridx | input | RIDX_W | Result index (unicast entry or multicast block) |
| pkt_mcast | input | 1 | 1 = multicast |
| pkt_mask | input | FANOUT | Copy selection mask |
| pkt_slice | input | SLICE_W | Slice number |
| pkt_stats | input | 16 | Stats index |
| rt_we | input | 1 | Result table write |
| rt_waddr | input | RT_AW | Result table address |
| rt_wdata | input | 101 | Result entry word |
| lim_we | input | 1 | Load slice maximum |
| lim_wslice | input | SLICE_W | Slice to load |
| lim_wmax | input | CNT_W | New maximum |
| lim_rslice | input | SLICE_W | Slice to read |
| lim_rcur | output | CNT_W | Current count of read slice |
| lim_rmax | output | CNT_W | Maximum of read slice |
| lim_rover | output | CNT_W | Over-limit count of read slice |
| fh_valid | input | 1 | Free header handle offered |
| fh_ready | output | 1 | Engine takes the offered handle |
| fh_handle | input | HANDLE_W | Free header handle |
| q_valid | output | 1 | Queue request valid |
| q_ready | input | 1 | Queue request accepted |
| q_handle | output | HANDLE_W | Handle to enqueue |
| q_len | output | LEN_W | Frame length |
| q_stats | output | 16 | Stats index |
| q_qm | output | 2 | Queue manager number |
| q_sched | output | 3 | Scheduler number |
| q_queue | output | 15 | Per-scheduler queue |
| q_tun_da | output | 32 | Tunnel destination address |
| q_tun_dport | output | 16 | Tunnel destination port |
| q_tun_sport | output | 16 | Tunnel source port |
| q_hf_idx | output | 16 | Header-format index |
| drop_valid | output | 1 | Packet dropped (pulse) |
| pay_drop_valid | output | 1 | Empty payload buffer released (pulse) |
| pay_drop_handle | output | HANDLE_W | Handle of released payload |
| dsc_ridx | input | DESC_AW | Descriptor readback index |
| dsc_rref | output | REF_W | Reference count |
| dsc_rnext | output | HANDLE_W | Chained handle |
| dsc_rchain | output | 1 | Chain flag |

## Verification
Unicast traffic is driven against a valid entry, an invalid entry and a slice with a maximum of one. These runs separate a correct forward from a silent miss and from a limit refusal, and the limit refusal is confirmed through the over-limit count. The multicast mask mixes valid entries, an invalid entry and a high-order bit. This exposes wrong copy order, a reference count that includes skipped entries, and a wrong block base. Zero-length payload, a mask with no valid target, an empty free-handle source and a stalled queue each isolate one path: release of the payload buffer, drop without counting, waiting for a header buffer, and holding a request steady.

// File: rtl/mce_pkg.sv
package mce_pkg;
    typedef struct packed {
        logic        valid;
        logic [19:0] qid;
        logic [31:0] tun_da;
        logic [15:0] tun_dport;
        logic [15:0] tun_sport;
        logic [15:0] hf_idx;
    } rt_entry_t;

    localparam int ENTRY_W = $bits(rt_entry_t);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_UC_SEND,
        ST_MC_GRAB,
        ST_MC_SEND
    } eng_state_t;
endpackage

// File: rtl/mce_result_store.sv
module mce_result_store
    import mce_pkg::*;
#(
    parameter int UC_ENTRIES = 16,
    parameter int MC_BLOCKS  = 4,
    parameter int FANOUT     = 16,
    parameter int RIDX_W     = 8,
    localparam int DEPTH     = UC_ENTRIES + MC_BLOCKS * FANOUT,
    localparam int AW        = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  rt_entry_t         wdata,
    input  logic [RIDX_W-1:0] ridx,
    output rt_entry_t         uc_ent,
    output rt_entry_t         mc_ent [FANOUT]
);
    rt_entry_t tbl [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
        end else if (we && int'(waddr) < DEPTH) begin
            tbl[waddr] <= wdata;
        end
    end

    always_comb begin
        uc_ent = '0;
        if (int'(ridx) < UC_ENTRIES) uc_ent = tbl[AW'(ridx)];
    end

    for (genvar k = 0; k < FANOUT; k++) begin : g_blk
        always_comb begin
            mc_ent[k] = '0;
            if (int'(ridx) < MC_BLOCKS)
                mc_ent[k] = tbl[AW'(UC_ENTRIES + int'(ridx) * FANOUT + k)];
        end
    end
endmodule

// File: rtl/mce_slice_gate.sv
module mce_slice_gate #(
    parameter int NUM_SLICES = 8,
    parameter int CNT_W      = 8,
    localparam int SLICE_W   = $clog2(NUM_SLICES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SLICE_W-1:0] chk_slice,
    output logic               allow,
    input  logic               admit,
    input  logic               refuse,
    input  logic               ld_we,
    input  logic [SLICE_W-1:0] ld_slice,
    input  logic [CNT_W-1:0]   ld_max,
    input  logic [SLICE_W-1:0] rd_slice,
    output logic [CNT_W-1:0]   rd_cur,
    output logic [CNT_W-1:0]   rd_max,
    output logic [CNT_W-1:0]   rd_over
);
    logic [CNT_W-1:0] cur_q  [NUM_SLICES];
    logic [CNT_W-1:0] max_q  [NUM_SLICES];
    logic [CNT_W-1:0] over_q [NUM_SLICES];

    assign allow   = cur_q[chk_slice] < max_q[chk_slice];
    assign rd_cur  = cur_q[rd_slice];
    assign rd_max  = max_q[rd_slice];
    assign rd_over = over_q[rd_slice];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLICES; i++) begin
                cur_q[i]  <= '0;
                max_q[i]  <= '0;
                over_q[i] <= '0;
            end
        end else begin
            if (admit)  cur_q[chk_slice]  <= cur_q[chk_slice] + 1'b1;
            if (refuse) over_q[chk_slice] <= over_q[chk_slice] + 1'b1;
            if (ld_we) begin
                max_q[ld_slice]  <= ld_max;
                cur_q[ld_slice]  <= '0;
                over_q[ld_slice] <= '0;
            end
        end
    end

    assert_admit_below_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
        admit |-> (cur_q[chk_slice] < max_q[chk_slice]));
    assert_admit_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(admit && refuse));
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (admit && !ld_we) |=> (cur_q[$past(chk_slice)] == $past(cur_q[chk_slice]) + 1'b1));
endmodule

// File: rtl/mce_desc_file.sv
module mce_desc_file #(
    parameter int HANDLE_W = 24,
    parameter int DESC_AW  = 5,
    parameter int REF_W    = 8,
    parameter int FANOUT   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [DESC_AW-1:0]  widx,
    input  logic [REF_W-1:0]    wref,
    input  logic [HANDLE_W-1:0] wnext,
    input  logic                wchain,
    input  logic [DESC_AW-1:0]  ridx,
    output logic [REF_W-1:0]    rref,
    output logic [HANDLE_W-1:0] rnext,
    output logic                rchain
);
    localparam int DEPTH = 1 << DESC_AW;

    logic [REF_W-1:0]    ref_q   [DEPTH];
    logic [HANDLE_W-1:0] next_q  [DEPTH];
    logic                chain_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ref_q[i]   <= '0;
                next_q[i]  <= '0;
                chain_q[i] <= 1'b0;
            end
        end else if (we) begin
            ref_q[widx]   <= wref;
            next_q[widx]  <= wnext;
            chain_q[widx] <= wchain;
        end
    end

    assign rref   = ref_q[ridx];
    assign rnext  = next_q[ridx];
    assign rchain = chain_q[ridx];

    assert_refcnt_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (wref != '0 && int'(wref) <= FANOUT));
endmodule

// File: rtl/mc_copy_engine.sv
module mc_copy_engine
    import mce_pkg::*;
#(
    parameter int HANDLE_W   = 24,
    parameter int LEN_W      = 16,
    parameter int RIDX_W     = 8,
    parameter int FANOUT     = 16,
    parameter int UC_ENTRIES = 16,
    parameter int MC_BLOCKS  = 4,
    parameter int NUM_SLICES = 8,
    parameter int CNT_W      = 8,
    parameter int DESC_AW    = 5,
    parameter int REF_W      = 8,
    localparam int SLICE_W   = $clog2(NUM_SLICES),
    localparam int RT_AW     = $clog2(UC_ENTRIES + MC_BLOCKS * FANOUT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pkt_valid,
    output logic                pkt_ready,
    input  logic [HANDLE_W-1:0] pkt_handle,
    input  logic [LEN_W-1:0]    pkt_len,
    input  logic [RIDX_W-1:0]   pkt_ridx,
    input  logic                pkt_mcast,
    input  logic [FANOUT-1:0]   pkt_mask,
    input  logic [SLICE_W-1:0]  pkt_slice,
    input  logic [15:0]         pkt_stats,
    input  logic                rt_we,
    input  logic [RT_AW-1:0]    rt_waddr,
    input  logic [ENTRY_W-1:0]  rt_wdata,
    input  logic                lim_we,
    input  logic [SLICE_W-1:0]  lim_wslice,
    input  logic [CNT_W-1:0]    lim_wmax,
    input  logic [SLICE_W-1:0]  lim_rslice,
    output logic [CNT_W-1:0]    lim_rcur,
    output logic [CNT_W-1:0]    lim_rmax,
    output logic [CNT_W-1:0]    lim_rover,
    input  logic                fh_valid,
    output logic                fh_ready,
    input  logic [HANDLE_W-1:0] fh_handle,
    output logic                q_valid,
    input  logic                q_ready,
    output logic [HANDLE_W-1:0] q_handle,
    output logic [LEN_W-1:0]    q_len,
    output logic [15:0]         q_stats,
    output logic [1:0]          q_qm,
    output logic [2:0]          q_sched,
    output logic [14:0]         q_queue,
    output logic [31:0]         q_tun_da,
    output logic [15:0]         q_tun_dport,
    output logic [15:0]         q_tun_sport,
    output logic [15:0]         q_hf_idx,
    output logic                drop_valid,
    output logic                pay_drop_valid,
    output logic [HANDLE_W-1:0] pay_drop_handle,
    input  logic [DESC_AW-1:0]  dsc_ridx,
    output logic [REF_W-1:0]    dsc_rref,
    output logic [HANDLE_W-1:0] dsc_rnext,
    output logic                dsc_rchain
);
    localparam int PICK_W = (FANOUT > 1) ? $clog2(FANOUT) : 1;

    eng_state_t st_q, st_d;

    logic [HANDLE_W-1:0] pk_handle_q, hdr_q;
    logic [LEN_W-1:0]    pk_len_q;
    logic [RIDX_W-1:0]   pk_ridx_q;
    logic                pk_mcast_q;
    logic [FANOUT-1:0]   pk_mask_q, rem_q, sel, pick_oh;
    logic [SLICE_W-1:0]  pk_slice_q;
    logic [15:0]         pk_stats_q;
    logic [PICK_W-1:0]   pick_idx;

    rt_entry_t uc_ent, cur_ent;
    rt_entry_t mc_ent [FANOUT];

    logic has_work, allow, admit, refuse, empty_pay;
    logic                dsc_we, dsc_wchain;
    logic [DESC_AW-1:0]  dsc_widx;
    logic [REF_W-1:0]    dsc_wref;
    logic [HANDLE_W-1:0] dsc_wnext;

    mce_result_store #(
        .UC_ENTRIES(UC_ENTRIES), .MC_BLOCKS(MC_BLOCKS),
        .FANOUT(FANOUT), .RIDX_W(RIDX_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .we(rt_we), .waddr(rt_waddr),
        .wdata(rt_entry_t'(rt_wdata)), .ridx(pk_ridx_q),
        .uc_ent(uc_ent), .mc_ent(mc_ent)
    );

    mce_slice_gate #(.NUM_SLICES(NUM_SLICES), .CNT_W(CNT_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .chk_slice(pk_slice_q), .allow(allow),
        .admit(admit), .refuse(refuse), .ld_we(lim_we), .ld_slice(lim_wslice),
        .ld_max(lim_wmax), .rd_slice(lim_rslice), .rd_cur(lim_rcur),
        .rd_max(lim_rmax), .rd_over(lim_rover)
    );

    mce_desc_file #(
        .HANDLE_W(HANDLE_W), .DESC_AW(DESC_AW), .REF_W(REF_W), .FANOUT(FANOUT)
    ) u_desc (
        .clk(clk), .rst_n(rst_n), .we(dsc_we), .widx(dsc_widx), .wref(dsc_wref),
        .wnext(dsc_wnext), .wchain(dsc_wchain), .ridx(dsc_ridx),
        .rref(dsc_rref), .rnext(dsc_rnext), .rchain(dsc_rchain)
    );

    // Valid targets of the current multicast block
    for (genvar k = 0; k < FANOUT; k++) begin : g_sel
        assign sel[k] = pk_mask_q[k] & mc_ent[k].valid;
    end

    assign pick_oh = rem_q & (~rem_q + 1'b1);
    always_comb begin
        pick_idx = '0;
        for (int k = FANOUT - 1; k >= 0; k--)
            if (rem_q[k]) pick_idx = PICK_W'(k);
    end

    assign empty_pay = (pk_len_q == '0);
    assign has_work  = pk_mcast_q ? (|sel) : uc_ent.valid;
    assign admit     = (st_q == ST_CHECK) && has_work && allow;
    assign refuse    = (st_q == ST_CHECK) && has_work && !allow;

    // State and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            pk_handle_q <= '0;
            pk_len_q    <= '0;
            pk_ridx_q   <= '0;
            pk_mcast_q  <= 1'b0;
            pk_mask_q   <= '0;
            pk_slice_q  <= '0;
            pk_stats_q  <= '0;
            rem_q       <= '0;
            hdr_q       <= '0;
        end else begin
            st_q <= st_d;
            unique case (st_q)
                ST_IDLE: if (pkt_valid) begin
                    pk_handle_q <= pkt_handle;
                    pk_len_q    <= pkt_len;
                    pk_ridx_q   <= pkt_ridx;
                    pk_mcast_q  <= pkt_mcast;
                    pk_mask_q   <= pkt_mask;
                    pk_slice_q  <= pkt_slice;
                    pk_stats_q  <= pkt_stats;
                end
                ST_CHECK:   rem_q <= sel;
                ST_UC_SEND: ;
                ST_MC_GRAB: if (fh_valid) hdr_q <= fh_handle;
                ST_MC_SEND: if (q_ready) rem_q <= rem_q & ~pick_oh;
                default: ;
            endcase
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (pkt_valid) st_d = ST_CHECK;
            ST_CHECK:   st_d = !admit ? ST_IDLE : (pk_mcast_q ? ST_MC_GRAB : ST_UC_SEND);
            ST_UC_SEND: if (q_ready) st_d = ST_IDLE;
            ST_MC_GRAB: if (fh_valid) st_d = ST_MC_SEND;
            ST_MC_SEND: if (q_ready) st_d = ((rem_q & ~pick_oh) == '0) ? ST_IDLE : ST_MC_GRAB;
            default:    st_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        pkt_ready      = (st_q == ST_IDLE);
        fh_ready       = (st_q == ST_MC_GRAB);
        q_valid        = (st_q == ST_UC_SEND) || (st_q == ST_MC_SEND);
        q_handle       = (st_q == ST_MC_SEND) ? hdr_q : pk_handle_q;
        cur_ent        = (st_q == ST_MC_SEND) ? mc_ent[pick_idx] : uc_ent;
        drop_valid     = (st_q == ST_CHECK) && !admit;
        pay_drop_valid = admit && pk_mcast_q && empty_pay;
        dsc_we         = 1'b0;
        dsc_widx       = pk_handle_q[DESC_AW-1:0];
        dsc_wref       = REF_W'($countones(sel));
        dsc_wnext      = '0;
        dsc_wchain     = 1'b0;
        if (admit && pk_mcast_q && !empty_pay) begin
            dsc_we = 1'b1;
        end else if (st_q == ST_MC_GRAB && fh_valid) begin
            dsc_we     = 1'b1;
            dsc_widx   = fh_handle[DESC_AW-1:0];
            dsc_wref   = REF_W'(1);
            dsc_wnext  = pk_handle_q;
            dsc_wchain = !empty_pay;
        end
    end

    assign pay_drop_handle = pk_handle_q;
    assign q_len       = pk_len_q;
    assign q_stats     = pk_stats_q;
    assign q_qm        = cur_ent.qid[19:18];
    assign q_sched     = cur_ent.qid[17:15];
    assign q_queue     = cur_ent.qid[14:0];
    assign q_tun_da    = cur_ent.tun_da;
    assign q_tun_dport = cur_ent.tun_dport;
    assign q_tun_sport = cur_ent.tun_sport;
    assign q_hf_idx    = cur_ent.hf_idx;

    assert_hold_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && !q_ready) |=> (q_valid && $stable(q_handle) && $stable(q_queue)
                                   && $stable(q_qm) && $stable(q_sched)));
    assert_one_packet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_ready) |=> !pkt_ready);
    assert_no_drop_with_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
        drop_valid |=> !q_valid);
    assert_copy_counts_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_MC_SEND && q_ready) |=> ($countones(rem_q) == $countones($past(rem_q)) - 1));
endmodule

// File: tb/mc_copy_engine_tb.sv
module mc_copy_engine_tb;
    import mce_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        pkt_valid = 0, pkt_ready, pkt_mcast = 0;
    logic [23:0] pkt_handle = 0;
    logic [15:0] pkt_len = 0, pkt_mask = 0, pkt_stats = 0;
    logic [7:0]  pkt_ridx = 0;
    logic [2:0]  pkt_slice = 0;
    logic        rt_we = 0;
    logic [6:0]  rt_waddr = 0;
    logic [100:0] rt_wdata = 0;
    logic        lim_we = 0;
    logic [2:0]  lim_wslice = 0, lim_rslice = 0;
    logic [7:0]  lim_wmax = 0, lim_rcur, lim_rmax, lim_rover;
    logic        fh_valid, fh_ready;
    logic [23:0] fh_handle;
    logic        q_valid, q_ready = 1;
    logic [23:0] q_handle, pay_drop_handle, dsc_rnext;
    logic [15:0] q_len, q_stats, q_tun_dport, q_tun_sport, q_hf_idx;
    logic [1:0]  q_qm;
    logic [2:0]  q_sched;
    logic [14:0] q_queue;
    logic [31:0] q_tun_da;
    logic        drop_valid, pay_drop_valid, dsc_rchain;
    logic [4:0]  dsc_ridx = 0;
    logic [7:0]  dsc_rref;

    mc_copy_engine u_dut (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
        .pkt_handle(pkt_handle), .pkt_len(pkt_len), .pkt_ridx(pkt_ridx),
        .pkt_mcast(pkt_mcast), .pkt_mask(pkt_mask), .pkt_slice(pkt_slice),
        .pkt_stats(pkt_stats), .rt_we(rt_we), .rt_waddr(rt_waddr), .rt_wdata(rt_wdata),
        .lim_we(lim_we), .lim_wslice(lim_wslice), .lim_wmax(lim_wmax),
        .lim_rslice(lim_rslice), .lim_rcur(lim_rcur), .lim_rmax(lim_rmax),
        .lim_rover(lim_rover), .fh_valid(fh_valid), .fh_ready(fh_ready),
        .fh_handle(fh_handle), .q_valid(q_valid), .q_ready(q_ready),
        .q_handle(q_handle), .q_len(q_len), .q_stats(q_stats), .q_qm(q_qm),
        .q_sched(q_sched), .q_queue(q_queue), .q_tun_da(q_tun_da),
        .q_tun_dport(q_tun_dport), .q_tun_sport(q_tun_sport), .q_hf_idx(q_hf_idx),
        .drop_valid(drop_valid), .pay_drop_valid(pay_drop_valid),
        .pay_drop_handle(pay_drop_handle), .dsc_ridx(dsc_ridx), .dsc_rref(dsc_rref),
        .dsc_rnext(dsc_rnext), .dsc_rchain(dsc_rchain)
    );

    // Free header-handle source
    logic [23:0] fl [32];
    int fl_n = 0, fl_rd = 0;
    logic fh_en = 1;
    assign fh_valid  = fh_en && (fl_rd < fl_n);
    assign fh_handle = fl[fl_rd[4:0]];
    always @(posedge clk) if (fh_valid && fh_ready) fl_rd <= fl_rd + 1;

    // Output monitor
    int n_req = 0, n_drop = 0, n_pdrop = 0;
    logic [23:0] r_handle [64];
    logic [14:0] r_queue [64];
    logic [1:0]  r_qm [64];
    logic [2:0]  r_sched [64];
    logic [15:0] r_hf [64];
    logic [15:0] r_stats [64];
    logic [23:0] last_pdrop = 0;
    always @(negedge clk) if (rst_n) begin
        if (q_valid && q_ready && n_req < 64) begin
            r_handle[n_req] = q_handle; r_queue[n_req] = q_queue;
            r_qm[n_req] = q_qm; r_sched[n_req] = q_sched;
            r_hf[n_req] = q_hf_idx; r_stats[n_req] = q_stats;
            n_req++;
        end
        if (drop_valid) n_drop++;
        if (pay_drop_valid) begin n_pdrop++; last_pdrop = pay_drop_handle; end
    end

    int checks = 0, fails = 0, cyc = 0;

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [100:0] mk_ent(input logic v, input logic [19:0] qid,
                                             input logic [15:0] hf);
        return {v, qid, 32'hC0A80001, 16'd5000, 16'd6000, hf};
    endfunction

    task automatic drive_tick(); @(posedge clk); #1; endtask

    task automatic rt_write(input int addr, input logic [100:0] w);
        rt_we = 1; rt_waddr = 7'(addr); rt_wdata = w;
        drive_tick();
        rt_we = 0;
    endtask

    task automatic lim_load(input int s, input int mx);
        lim_we = 1; lim_wslice = 3'(s); lim_wmax = 8'(mx);
        drive_tick();
        lim_we = 0;
    endtask

    task automatic send(input logic [23:0] h, input logic [15:0] len, input int ridx,
                        input logic mc, input logic [15:0] mask, input int sl,
                        input logic [15:0] st);
        pkt_valid = 1; pkt_handle = h; pkt_len = len; pkt_ridx = 8'(ridx);
        pkt_mcast = mc; pkt_mask = mask; pkt_slice = 3'(sl); pkt_stats = st;
        drive_tick();
        pkt_valid = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        for (int i = 0; i < 200 && !pkt_ready; i++) @(negedge clk);
    endtask

    task automatic read_lim(input int s, output int cur, output int over);
        lim_rslice = 3'(s); #1; cur = lim_rcur; over = lim_rover;
    endtask

    task automatic read_dsc(input int idx, output int rf, output int nx, output int ch);
        dsc_ridx = 5'(idx); #1; rf = dsc_rref; nx = dsc_rnext; ch = dsc_rchain;
    endtask

    task automatic t_reset();
        int c, o;
        @(negedge clk);
        chk("R1 pkt_ready", pkt_ready, 1);
        chk("R1 q_valid", q_valid, 0);
        chk("R1 drop_valid", drop_valid, 0);
        read_lim(0, c, o);
        chk("R1 cur", c, 0);
        chk("R1 over", o, 0);
    endtask

    task automatic t_unicast();
        int base = n_req, c, o;
        send(24'h000A01, 16'd100, 3, 0, 16'h0, 0, 16'd7);
        wait_idle();
        chk("R2 one request", n_req - base, 1);
        chk("R2 handle", r_handle[base], 24'h000A01);
        chk("R2 stats", r_stats[base], 7);
        chk("R2 hf index", r_hf[base], 16'h0AAA);
        chk("R3 qm", r_qm[base], 2);
        chk("R3 sched", r_sched[base], 5);
        chk("R3 queue", r_queue[base], 15'h1234);
        read_lim(0, c, o);
        chk("R4 admit count", c, 1);
    endtask

    task automatic t_uc_invalid();
        int base = n_req, d = n_drop, c, o;
        send(24'h000A09, 16'd60, 4, 0, 16'h0, 0, 16'd1);
        wait_idle();
        chk("R8 no request", n_req - base, 0);
        chk("R8 dropped", n_drop - d, 1);
        read_lim(0, c, o);
        chk("R8 cur unchanged", c, 1);
        chk("R8 over unchanged", o, 0);
    endtask

    task automatic t_limit();
        int base = n_req, d = n_drop, c, o;
        send(24'h000A05, 16'd80, 3, 0, 16'h0, 1, 16'd2);
        wait_idle();
        send(24'h000A06, 16'd80, 3, 0, 16'h0, 1, 16'd2);
        wait_idle();
        chk("R4 only first forwarded", n_req - base, 1);
        chk("R4 refused dropped", n_drop - d, 1);
        read_lim(1, c, o);
        chk("R4 cur at max", c, 1);
        chk("R4 over count", o, 1);
    endtask

    task automatic t_mcast();
        int base = n_req, rf, nx, ch, c, o;
        int exp_k [4] = '{0, 2, 5, 15};
        send(24'h000A02, 16'd64, 1, 1, 16'h80A5, 0, 16'd9);
        wait_idle();
        chk("R5 copy count", n_req - base, 4);
        for (int i = 0; i < 4; i++) begin
            chk("R5 header handle", r_handle[base+i], 24'h000010 + i);
            chk("R5 ascending queue", r_queue[base+i], 15'h100 + exp_k[i]);
        end
        read_dsc(2, rf, nx, ch);
        chk("R6 payload refcnt", rf, 4);
        read_dsc(16, rf, nx, ch);
        chk("R6 header next", nx, 24'h000A02);
        chk("R6 header chained", ch, 1);
        chk("R6 header refcnt", rf, 1);
        read_lim(0, c, o);
        chk("R4 multicast admitted once", c, 2);
    endtask

    task automatic t_mc_zero();
        int base = n_req, p = n_pdrop, rf, nx, ch;
        send(24'h000A03, 16'd0, 1, 1, 16'h0005, 0, 16'd3);
        wait_idle();
        chk("R7 copies", n_req - base, 2);
        chk("R7 payload released", n_pdrop - p, 1);
        chk("R7 released handle", last_pdrop, 24'h000A03);
        read_dsc(3, rf, nx, ch);
        chk("R7 payload desc untouched", rf, 0);
        read_dsc(20, rf, nx, ch);
        chk("R7 header not chained", ch, 0);
    endtask

    task automatic t_mc_none();
        int base = n_req, d = n_drop, c, o;
        send(24'h000A07, 16'd40, 1, 1, 16'h0080, 0, 16'd3);
        wait_idle();
        chk("R8 invalid-only mask no copy", n_req - base, 0);
        chk("R8 invalid-only mask dropped", n_drop - d, 1);
        read_lim(0, c, o);
        chk("R8 cur unchanged mc", c, 3);
    endtask

    task automatic t_stall();
        int base = n_req;
        fh_en = 0;
        send(24'h000A04, 16'd32, 1, 1, 16'h0005, 0, 16'd4);
        repeat (10) @(negedge clk);
        chk("R9 no copy while starved", n_req - base, 0);
        chk("R9 pkt_ready held low", pkt_ready, 0);
        drive_tick();
        fh_en = 1;
        wait_idle();
        chk("R9 copies after supply", n_req - base, 2);
        chk("R9 first handle", r_handle[base], 24'h000016);
        chk("R9 second handle", r_handle[base+1], 24'h000017);
    endtask

    task automatic t_backpressure();
        int base = n_req;
        drive_tick();
        q_ready = 0;
        send(24'h000A08, 16'd50, 3, 0, 16'h0, 0, 16'd5);
        repeat (5) @(negedge clk);
        chk("R10 q_valid held", q_valid, 1);
        chk("R10 handle held", q_handle, 24'h000A08);
        chk("R10 queue held", q_queue, 15'h1234);
        chk("R10 nothing taken", n_req - base, 0);
        drive_tick();
        q_ready = 1;
        wait_idle();
        chk("R10 taken once", n_req - base, 1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) fl[i] = 24'h000010 + 24'(i);
        fl_n = 16;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        drive_tick();
        rt_write(3, mk_ent(1, {2'd2, 3'd5, 15'h1234}, 16'h0AAA));
        rt_write(4, mk_ent(0, {2'd1, 3'd1, 15'h0001}, 16'h0001));
        for (int k = 0; k < 16; k++)
            rt_write(32 + k, mk_ent(k == 0 || k == 2 || k == 5 || k == 15,
                                    {2'd1, 3'(k % 8), 15'(16'h100 + k)}, 16'(k)));
        lim_load(0, 8);
        lim_load(1, 1);
        t_unicast();
        t_uc_invalid();
        t_limit();
        t_mcast();
        t_mc_zero();
        t_mc_none();
        t_stall();
        t_backpressure();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule